// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block is the transmit half of a host-side stereo audio port. It divides the system clock down to a bit clock (`sck`), produces the frame clock (`lrc`) and shifts one left and one right sample per frame out on `sdo`. The most significant bit always goes first. Four framing conventions are supported: I2S, left-justified, right-justified and PCM/DSP. They differ in where the MSB sits relative to the frame-clock edge and in the polarity or shape of `lrc`.

Samples are offered as a left/right pair with a ready level (`sampleValid`). The pair is taken at the start of every frame. A one-cycle `sampleReq` pulse tells the producer that the pair has been taken, so the next one can be presented. If no pair is ready, the last pair is sent again and `underrun` is raised. Every bit clock that carries no data bit drives a zero. Format, width, frame length and divider are configuration inputs. They are meant to be held steady while `rstN` is high.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rstN` is low, on the next rising clock edge `sck`, `sdo`, `sampleReq` and `underrun` go to 0. `lrc` goes to 1 when `fmtSel`=0 (I2S) and to 0 for the other formats.
- R2: `sck` stays high for `divHalf`+1 clock cycles and then low for `divHalf`+1 clock cycles. `sdo` and `lrc` change only in the clock cycle in which `sck` falls.
- R3: A frame lasts 32, 64 or 256 `sck` periods for `frameSel` 0, 1 or 2 (3 also gives 256). Each half of a frame is one channel slot, left first. Slots are numbered from 0 at the first falling `sck` after reset.
- R4: The sample is taken from the low bits of the input word, and input bits above it are ignored. `widthSel` 0/1/2/3 selects 16/20/24/32 bits. A 20-bit sample is sent as a 24-bit word: its 20 bits, MSB first, then four zeros. Bits go out MSB first.
- R5: Every slot that carries no data bit drives 0 on `sdo`.
- R6: I2S (`fmtSel`=0): `lrc` is 0 in the left half and 1 in the right half. The word's MSB is in slot 1 of its half. If the word fills the whole half, its last bit falls into slot 0 of the following half. Any bits beyond the half are not sent.
- R7: Left-justified (`fmtSel`=1): `lrc` is 1 in the left half and 0 in the right half. The MSB is in slot 0 of its half. Bits beyond the half are not sent.
- R8: Right-justified (`fmtSel`=2): the `lrc` polarity is the same as in R7. The LSB is in the last slot of its half. When the word is wider than the half, its leading bits are not sent.
- R9: PCM/DSP (`fmtSel`=3): the left word starts at frame slot 0 (`pcmLateStart`=0) or at frame slot 1 (`pcmLateStart`=1). The right word follows with no gap. Bits that would fall past the end of the frame are not sent.
- R10: In PCM/DSP, `lrc` is 1 only in frame slot 0 when `pcmLongSync`=0. When `pcmLongSync`=1 it is 1 for as many slots as the word has bits (24 for a 20-bit sample).
- R11: At each frame start where `sampleValid` is 1, the pair on `leftData`/`rightData` is sent in that frame. `sampleReq` pulses high for exactly one clock cycle, and `underrun` goes to 0.
- R12: At a frame start where `sampleValid` is 0, the previous pair is sent again. `underrun` goes to 1 and stays there until a frame start that has a pair ready, and no `sampleReq` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| fmtSel | input | 2 | Framing convention: 0 I2S, 1 left-justified, 2 right-justified, 3 PCM/DSP |
| widthSel | input | 2 | Sample width: 0=16, 1=20, 2=24, 3=32 bits |
| frameSel | input | 2 | Frame length: 0=32, 1=64, 2/3=256 bit clocks |
| pcmLateStart | input | 1 | PCM/DSP: left MSB one slot after the frame edge |
| pcmLongSync | input | 1 | PCM/DSP: frame pulse as wide as the word |
| divHalf | input | DIV_W | Bit-clock half period minus one, in clock cycles |
| leftData | input | 32 | Left sample, right-aligned |
| rightData | input | 32 | Right sample, right-aligned |
| sampleValid | input | 1 | A sample pair is ready |
| sck | output | 1 | Serial bit clock |
| lrc | output | 1 | Frame / channel clock |
| sdo | output | 1 | Serial data, changes on falling `sck` |
| sampleReq | output | 1 | One-cycle pulse: the pair has been taken |
| underrun | output | 1 | The current frame repeats the previous pair |

## Verification
The slot counter is the one piece of state that every output depends on. If it is off by one, or wraps at the wrong length, an MSB lands in the wrong position. That shows on `sdo` at the first data bit of the first frame, a few bit clocks after reset, and `lrc` edges shift within the same frame. A wrongly latched or stale sample pair is visible within one frame as wrong bits. A bad handshake state shows at the first frame boundary as a missing or doubled `sampleReq` or a wrong `underrun` level. A divider fault shows on `sck` within its first period.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  parameter int SAMPLE_W  = 32;
  parameter int MAX_FRAME = 256;
  localparam int SLOT_W   = $clog2(MAX_FRAME);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_PCM = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txEdge;      // sck falls in this cycle
    logic frameStart;  // the falling edge opens slot 0
  } txStrobe_t;

  function automatic int frameLenOf(logic [1:0] sel);
    case (sel)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return MAX_FRAME;
    endcase
  endfunction

  // bits occupied on the line (20-bit samples travel as 24)
  function automatic int wordLenOf(logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd3:    return 32;
      default: return 24;
    endcase
  endfunction

  // move a right-aligned sample to the MSB end, zero below it
  function automatic logic [SAMPLE_W-1:0] alignWord(logic [SAMPLE_W-1:0] x, logic [1:0] sel);
    case (sel)
      2'd0:    return {x[15:0], 16'b0};
      2'd1:    return {x[19:0], 12'b0};
      2'd2:    return {x[23:0], 8'b0};
      default: return x;
    endcase
  endfunction

endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic [1:0]        frameSel,
  output logic              sck,
  output logic [SLOT_W-1:0] slotNext,
  output txStrobe_t         strobe
);

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slot;
  logic              lastSlot;
  logic              halfDone;

  assign halfDone = (divCnt == divHalf);
  assign lastSlot = int'(slot) >= frameLenOf(frameSel) - 1;
  assign slotNext = lastSlot ? '0 : slot + 1'b1;

  assign strobe.txEdge     = sck && halfDone;
  assign strobe.frameStart = sck && halfDone && lastSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sck    <= 1'b0;
      slot   <= '1;   // first falling edge opens slot 0
    end else if (halfDone) begin
      divCnt <= '0;
      sck    <= !sck;
      if (sck) slot <= slotNext;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/audtx_datapath.sv
module audtx_datapath
  import audtx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          widthSel,
  input  logic [1:0]          frameSel,
  input  logic                pcmLateStart,
  input  logic                pcmLongSync,
  input  logic [SAMPLE_W-1:0] leftData,
  input  logic [SAMPLE_W-1:0] rightData,
  input  logic                sampleValid,
  input  logic [SLOT_W-1:0]   slotNext,
  input  txStrobe_t           strobe,
  output logic                lrc,
  output logic                sdo,
  output logic                sampleReq,
  output logic                underrun
);

  logic [SAMPLE_W-1:0] heldL, heldR;
  logic [SAMPLE_W-1:0] wordL, wordR;
  logic                takePair;
  logic                lrcNext, bitNext;

  assign takePair = strobe.frameStart && sampleValid;
  // slot 0 of a new frame already carries the incoming left word;
  // the right word stays old there (I2S spill of the previous LSB)
  assign wordL = alignWord(takePair ? leftData : heldL, widthSel);
  assign wordR = alignWord(heldR, widthSel);

  always_comb begin
    int  s, half, w, c, k, p;
    logic inRight, useR, ok;
    logic [$clog2(SAMPLE_W)-1:0] bitIdx;
    s       = int'(slotNext);
    half    = frameLenOf(frameSel) / 2;
    w       = wordLenOf(widthSel);
    inRight = (s >= half);
    c       = inRight ? s - half : s;
    p       = s - int'(pcmLateStart);
    useR    = 1'b0;
    ok      = 1'b0;
    k       = 0;
    lrcNext = 1'b0;
    case (fmt_e'(fmtSel))
      FMT_I2S: begin
        lrcNext = inRight;
        if (c == 0) begin
          useR = !inRight;
          k    = half - 1;
        end else begin
          useR = inRight;
          k    = c - 1;
        end
        ok = (k < w);
      end
      FMT_LJ: begin
        lrcNext = !inRight;
        useR    = inRight;
        k       = c;
        ok      = (c < w);
      end
      FMT_RJ: begin
        lrcNext = !inRight;
        useR    = inRight;
        k       = c - (half - w);
        ok      = (k >= 0) && (k < w);
      end
      default: begin
        lrcNext = pcmLongSync ? (s < w) : (s == 0);
        if (p >= 0 && p < w) begin
          k  = p;
          ok = 1'b1;
        end else if (p >= w && p < 2 * w) begin
          useR = 1'b1;
          k    = p - w;
          ok   = 1'b1;
        end
      end
    endcase
    bitIdx  = ok ? ($clog2(SAMPLE_W))'(SAMPLE_W - 1 - k) : '0;
    bitNext = ok && (useR ? wordR[bitIdx] : wordL[bitIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldL     <= '0;
      heldR     <= '0;
      lrc       <= (fmtSel == FMT_I2S);
      sdo       <= 1'b0;
      sampleReq <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      sampleReq <= 1'b0;
      if (strobe.txEdge) begin
        lrc <= lrcNext;
        sdo <= bitNext;
      end
      if (strobe.frameStart) begin
        if (sampleValid) begin
          heldL     <= leftData;
          heldR     <= rightData;
          sampleReq <= 1'b1;
          underrun  <= 1'b0;
        end else begin
          underrun  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audtx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          widthSel,
  input  logic [1:0]          frameSel,
  input  logic                pcmLateStart,
  input  logic                pcmLongSync,
  input  logic [DIV_W-1:0]    divHalf,
  input  logic [SAMPLE_W-1:0] leftData,
  input  logic [SAMPLE_W-1:0] rightData,
  input  logic                sampleValid,
  output logic                sck,
  output logic                lrc,
  output logic                sdo,
  output logic                sampleReq,
  output logic                underrun
);

  logic [SLOT_W-1:0] slotNext;
  txStrobe_t         strobe;

  audtx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divHalf  (divHalf),
    .frameSel (frameSel),
    .sck      (sck),
    .slotNext (slotNext),
    .strobe   (strobe)
  );

  audtx_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fmtSel       (fmtSel),
    .widthSel     (widthSel),
    .frameSel     (frameSel),
    .pcmLateStart (pcmLateStart),
    .pcmLongSync  (pcmLongSync),
    .leftData     (leftData),
    .rightData    (rightData),
    .sampleValid  (sampleValid),
    .slotNext     (slotNext),
    .strobe       (strobe),
    .lrc          (lrc),
    .sdo          (sdo),
    .sampleReq    (sampleReq),
    .underrun     (underrun)
  );

endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       fmtSel,
  input logic [DIV_W-1:0] divHalf,
  input logic             sck,
  input logic             lrc,
  input logic             sdo,
  input logic             sampleReq,
  input logic             underrun
);

  logic             sckQ;
  logic [DIV_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ   <= 1'b0;
      runLen <= '1;
    end else begin
      sckQ   <= sck;
      runLen <= (sck != sckQ) ? '0 : runLen + 1'b1;
    end
  end

  AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (sck != sckQ) |-> (runLen == divHalf)); // R2

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $fell(sck)); // R2

  AST_LRC_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrc) |-> $fell(sck)); // R2

  AST_FRAME_EDGE_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && fmtSel != 2'd3) |-> !$stable(lrc)); // R3

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq); // R11

  AST_REQ_CLEARS_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> !underrun); // R11

  AST_UNDERRUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> ($fell(sck) && !sampleReq)); // R12

endmodule

bind audio_serial_tx audio_serial_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fmtSel    (fmtSel),
  .divHalf   (divHalf),
  .sck       (sck),
  .lrc       (lrc),
  .sdo       (sdo),
  .sampleReq (sampleReq),
  .underrun  (underrun)
);

// File: tb/test_audio_serial_tx.sv
`timescale 1ns/1ps
module test_audio_serial_tx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fmtSel = '0, widthSel = '0, frameSel = '0;
  logic        pcmLateStart = 1'b0, pcmLongSync = 1'b0;
  logic [7:0]  divHalf = '0;
  logic [31:0] leftData = '0, rightData = '0;
  logic        sampleValid = 1'b0;
  logic        sck, lrc, sdo, sampleReq, underrun;

  always #5 clk = ~clk;

  audio_serial_tx i_audio_serial_tx (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .widthSel(widthSel),
    .frameSel(frameSel), .pcmLateStart(pcmLateStart), .pcmLongSync(pcmLongSync),
    .divHalf(divHalf), .leftData(leftData), .rightData(rightData),
    .sampleValid(sampleValid), .sck(sck), .lrc(lrc), .sdo(sdo),
    .sampleReq(sampleReq), .underrun(underrun)
  );

  int checks = 0, failures = 0;
  logic [1:0] expQ[$];
  string curTag;
  int  frameLen, popCount, reqCount, riseGap;
  bit  monOn = 0, armed = 0, prevSck = 0, periodDone = 0;
  bit  finished = 0;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  function automatic logic [31:0] alignB(logic [31:0] x, int n);
    logic [63:0] t;
    t = {32'b0, x} & ((64'd1 << n) - 1);
    t = t << (32 - n);
    return t[31:0];
  endfunction

  function automatic logic [1:0] expSlot(int s, logic [31:0] L, logic [31:0] R, logic [31:0] pR);
    int n, w, half, c, k, p;
    logic rt, lr, b;
    logic [31:0] aL, aR, aP;
    n = (widthSel == 0) ? 16 : (widthSel == 1) ? 20 : (widthSel == 2) ? 24 : 32;
    w = (n == 20) ? 24 : n;
    half = frameLen / 2;
    rt = (s >= half);
    c = rt ? s - half : s;
    aL = alignB(L, n); aR = alignB(R, n); aP = alignB(pR, n);
    b = 1'b0; lr = 1'b0;
    case (fmtSel)
      2'd0: begin
        lr = rt;
        if (c == 0) begin
          k = half - 1;
          if (k < w) b = rt ? aL[31-k] : aP[31-k];
        end else begin
          k = c - 1;
          if (k < w) b = rt ? aR[31-k] : aL[31-k];
        end
      end
      2'd1: begin
        lr = !rt;
        if (c < w) b = rt ? aR[31-c] : aL[31-c];
      end
      2'd2: begin
        lr = !rt;
        k = c - (half - w);
        if (k >= 0 && k < w) b = rt ? aR[31-k] : aL[31-k];
      end
      default: begin
        p = s - int'(pcmLateStart);
        lr = pcmLongSync ? (s < w) : (s == 0);
        if (p >= 0 && p < w) b = aL[31-p];
        else if (p >= w && p < 2*w) b = aR[31-(p-w)];
      end
    endcase
    return {lr, b};
  endfunction

  task automatic pushFrame(logic [31:0] L, logic [31:0] R, logic [31:0] pR);
    for (int s = 0; s < frameLen; s++) expQ.push_back(expSlot(s, L, R, pR));
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (!rstN) begin
      prevSck = 0; armed = 0; riseGap = 0;
    end else begin
      riseGap++;
      if (sampleReq) reqCount++;
      if (sck && !prevSck) begin
        if (monOn) begin
          if (!armed) armed = 1;
          else begin
            if (!periodDone) begin
              periodDone = 1;
              check(riseGap == 2 * (int'(divHalf) + 1), "R2", "sck period",
                    64'(riseGap), 64'(2 * (int'(divHalf) + 1)));
            end
            if (expQ.size() == 0) check(0, curTag, "no expected slot", 0, 0);
            else begin
              logic [1:0] e;
              e = expQ.pop_front();
              check({lrc, sdo} == e, curTag, $sformatf("slot %0d {lrc,sdo}", popCount % frameLen),
                    64'({lrc, sdo}), 64'(e));
              popCount++;
            end
          end
        end
        riseGap = 0;
      end
      prevSck = sck;
    end
  end

  function automatic logic [31:0] mkL(int i);
    return 32'hA5C3_96E1 ^ (32'(i) * 32'h9E37_79B9);
  endfunction
  function automatic logic [31:0] mkR(int i);
    return {mkL(i + 7)[15:0], mkL(i + 3)[31:16]} ^ 32'h0F0F_3C3C;
  endfunction

  // ---------------- driver ----------------
  task automatic runCfg(int fmt, int wsel, int fsel, bit late, bit longS, int div,
                        int nFrames, int drop, string tag);
    logic [31:0] curL, curR, prR;
    int reqExp;
    rstN = 0; monOn = 0; periodDone = 0;
    fmtSel = 2'(fmt); widthSel = 2'(wsel); frameSel = 2'(fsel);
    pcmLateStart = late; pcmLongSync = longS; divHalf = 8'(div);
    frameLen = (fsel == 0) ? 32 : (fsel == 1) ? 64 : 256;
    curTag = tag; expQ.delete(); popCount = 0; reqCount = 0;
    curL = mkL(fmt * 16 + fsel); curR = mkR(fmt * 16 + wsel);
    leftData = curL; rightData = curR; sampleValid = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sck, sdo, sampleReq, underrun} == 4'b0, "R1", "reset sck/sdo/req/underrun",
          64'({sck, sdo, sampleReq, underrun}), 0);
    check(lrc == (fmt == 0), "R1", "reset lrc", 64'(lrc), 64'(fmt == 0));
    pushFrame(curL, curR, 32'h0);
    prR = curR;
    rstN = 1; monOn = 1;
    for (int f = 1; f <= nFrames; f++) begin
      while (popCount < (f - 1) * frameLen + 1) @(negedge clk);
      reqExp = f - ((drop >= 0 && drop <= f - 1) ? 1 : 0);
      check(underrun == (f - 1 == drop), (f - 1 == drop) ? "R12" : "R11", "underrun level",
            64'(underrun), 64'(f - 1 == drop));
      check(reqCount == reqExp, "R11", "sampleReq pulses", 64'(reqCount), 64'(reqExp));
      if (f == nFrames) break;
      if (f == drop) begin
        sampleValid = 0;
        leftData = ~curL; rightData = ~curR;   // not ready: must not be used (R12)
        pushFrame(curL, curR, prR);
        prR = curR;
      end else begin
        sampleValid = 1;
        curL = mkL(f * 5 + fmt); curR = mkR(f * 3 + wsel);
        leftData = curL; rightData = curR;
        pushFrame(curL, curR, prR);
        prR = curR;
      end
    end
    while (popCount < nFrames * frameLen) @(negedge clk);
    monOn = 0;
    check(expQ.size() == 0, tag, "leftover expected slots", 64'(expQ.size()), 0);
  endtask

  initial begin
    // fmt wsel fsel late long div frames drop
    runCfg(0, 0, 0, 0, 0, 1, 3, -1, "R4/R5/R6 i2s16 f32 spill");
    runCfg(0, 2, 1, 0, 0, 2, 4,  2, "R4/R5/R6/R12 i2s24 f64 drop");
    runCfg(0, 3, 1, 0, 0, 0, 3, -1, "R6 i2s32 f64 spill");
    runCfg(1, 1, 1, 0, 0, 1, 3, -1, "R4/R5/R7 lj20 f64");
    runCfg(1, 2, 0, 0, 0, 3, 3, -1, "R7 lj24 f32 truncate");
    runCfg(2, 0, 1, 0, 0, 1, 3,  1, "R5/R8/R12 rj16 f64 drop");
    runCfg(2, 3, 0, 0, 0, 0, 3, -1, "R8 rj32 f32 msb drop");
    runCfg(2, 2, 2, 0, 0, 0, 2, -1, "R3/R8 rj24 f256");
    runCfg(3, 0, 0, 0, 0, 1, 3, -1, "R9/R10 pcm16 f32 early short");
    runCfg(3, 2, 1, 1, 1, 1, 3, -1, "R9/R10 pcm24 f64 late long");
    runCfg(3, 3, 1, 1, 0, 0, 3, -1, "R9 pcm32 f64 late tail drop");
    runCfg(3, 1, 2, 0, 1, 0, 2, -1, "R3/R4/R9/R10 pcm20 f256 long");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired (%s)", curTag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule